// File: doc/BRIEF.md
# Eight-Pin GPIO Register Block with Address-Masked Data Access

This block is the register side of an eight-pin general-purpose I/O peripheral. A bus master reaches it through a 32-bit request port with a single valid strobe, a write flag, an address and write data. Read data comes back one cycle later, marked by a response strobe. The block holds the pin data, the pin directions, five eight-bit interrupt and mode configuration words, and the raw interrupt status. A separate edge and level detector uses these configuration words and reports events back through a per-pin set vector.

The data register sits behind a window of 256 words. Address bits [9:2] of the access act as a per-bit mask. One pin can then be driven or sampled without a read-modify-write sequence. Writes through the window can only change bits whose pins are outputs. Input bits follow the external pins through a synchronizer. A small read-only region at the top of the map returns fixed identification bytes. Any other access is undefined: a write there has no effect, and a read returns zero with an error flag.

Top module: `gpio8_regs`

## Requirements
- R1: After reset, the data, direction, sense, both-edges, event, interrupt-enable and mode words and the raw status are all zero. `pin_oe` and `pin_out` are therefore zero.
- R2: A write to any offset below 0x400 updates only those data bits whose bit in address [9:2] is 1 and whose direction bit is 1. The new value takes effect on the next clock. `pin_out` equals data ANDed with direction.
- R3: A read at an offset below 0x400 returns the data register ANDed with address [9:2] in bits [7:0], with zeros above. Data bits of input pins, where direction is 0, take the value of `pin_in` after SYNC_STAGES+1 clock edges.
- R4: The direction (0x400), sense (0x404), both-edges (0x408), event (0x40C), interrupt-enable (0x410) and mode (0x420) words keep only bits [7:0] of a write. They read back zero-extended and drive their matching output ports.
- R5: Reading offset 0x414 returns the raw status. Reading 0x418 returns the raw status ANDed with the interrupt-enable word. `irq_out` is 1 exactly when that AND is non-zero.
- R6: A write to 0x41C clears each raw status bit whose write-data bit is 1. A 1 on `irq_set` sets that raw bit on the next clock. If a set and a clear hit the same bit in the same cycle, the set wins.
- R7: Reads of offsets 0xFE0 to 0xFFC return one byte zero-extended. Taken by word index (offset-0xFE0)>>2 from 0 to 7, the bytes are 0x61, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R8: A write to an undefined offset changes no state. This includes 0x414, 0x418, 0x424 to 0xFDC and the identification region.
- R9: A read of an undefined offset returns zero with `rsp_err` at 1 for that one response cycle. 0x41C counts as undefined for reads.
- R10: Each read request produces exactly one `rsp_valid` pulse on the clock after the request. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset; bits [1:0] are ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Read targeted an undefined offset |
| pin_in | input | 8 | External pin levels, asynchronous |
| pin_out | output | 8 | Output pin levels (data AND direction) |
| pin_oe | output | 8 | Direction word, 1 = output |
| irq_set | input | 8 | Per-pin event from the detector |
| cfg_sense | output | 8 | Level/edge select to the detector |
| cfg_both | output | 8 | Both-edges select to the detector |
| cfg_event | output | 8 | Polarity select to the detector |
| cfg_ie | output | 8 | Interrupt-enable word |
| cfg_mode | output | 8 | Mode-select word |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
The bench writes through masks that overlap input pins. A design that ignored direction would drive those pins, and one that ignored the address mask would corrupt neighbouring bits. Reads use partial masks while the pins hold a pattern different from the outputs. A wrong read mask or a stuck synchronizer would then return a wrong mix. The clear register is hit in the same cycle as a set on the same bit, so clear-wins priority loses an event. Writes to the identification region and to reserved space are followed by read-back of the configuration. Reads of 0x41C and reserved space must raise the error flag for exactly one cycle with zero data.

// File: rtl/gpio8_regs.sv
module gpio8_regs #(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic [7:0]        pin_in,
  output logic [7:0]        pin_out,
  output logic [7:0]        pin_oe,
  input  logic [7:0]        irq_set,
  output logic [7:0]        cfg_sense,
  output logic [7:0]        cfg_both,
  output logic [7:0]        cfg_event,
  output logic [7:0]        cfg_ie,
  output logic [7:0]        cfg_mode,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] OFS_DIR   = ADDR_W'(12'h400);
  localparam logic [ADDR_W-1:0] OFS_SENSE = ADDR_W'(12'h404);
  localparam logic [ADDR_W-1:0] OFS_BOTH  = ADDR_W'(12'h408);
  localparam logic [ADDR_W-1:0] OFS_EVENT = ADDR_W'(12'h40C);
  localparam logic [ADDR_W-1:0] OFS_IE    = ADDR_W'(12'h410);
  localparam logic [ADDR_W-1:0] OFS_RAW   = ADDR_W'(12'h414);
  localparam logic [ADDR_W-1:0] OFS_MIS   = ADDR_W'(12'h418);
  localparam logic [ADDR_W-1:0] OFS_CLR   = ADDR_W'(12'h41C);
  localparam logic [ADDR_W-1:0] OFS_MODE  = ADDR_W'(12'h420);
  localparam logic [ADDR_W-1:0] OFS_ID    = ADDR_W'(12'hFE0);

  logic [SYNC_STAGES-1:0][7:0] sync_q;
  logic [7:0] data_q, dir_q, sense_q, both_q, event_q, ie_q, mode_q, raw_q;
  logic [ADDR_W-1:0] wa;
  logic [7:0] amask, wmask, id_byte, data_nxt;
  logic in_data, in_id, wr, rd;
  logic [31:0] rd_val;
  logic rd_bad;

  assign wa      = {req_addr[ADDR_W-1:2], 2'b00};
  assign amask   = req_addr[9:2];
  assign in_data = (wa < OFS_DIR);
  assign in_id   = (wa >= OFS_ID);
  assign wr      = req_valid && req_write;
  assign rd      = req_valid && !req_write;
  assign wmask   = (wr && in_data) ? (amask & dir_q) : 8'h00;

  assign data_nxt = (dir_q & ((data_q & ~wmask) | (req_wdata[7:0] & wmask)))
                  | (~dir_q & sync_q[SYNC_STAGES-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      ie_q    <= '0;
      mode_q  <= '0;
      raw_q   <= '0;
    end else begin
      data_q <= data_nxt;
      if (wr && wa == OFS_DIR)   dir_q   <= req_wdata[7:0];
      if (wr && wa == OFS_SENSE) sense_q <= req_wdata[7:0];
      if (wr && wa == OFS_BOTH)  both_q  <= req_wdata[7:0];
      if (wr && wa == OFS_EVENT) event_q <= req_wdata[7:0];
      if (wr && wa == OFS_IE)    ie_q    <= req_wdata[7:0];
      if (wr && wa == OFS_MODE)  mode_q  <= req_wdata[7:0];
      if (wr && wa == OFS_CLR)   raw_q   <= (raw_q & ~req_wdata[7:0]) | irq_set;
      else                       raw_q   <= raw_q | irq_set;
    end
  end

  always_comb begin
    case (wa[4:2])
      3'd0:    id_byte = 8'h61;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h14;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  end

  always_comb begin
    rd_val = '0;
    rd_bad = 1'b0;
    if (in_data)             rd_val[7:0] = data_q & amask;
    else if (in_id)          rd_val[7:0] = id_byte;
    else if (wa == OFS_DIR)   rd_val[7:0] = dir_q;
    else if (wa == OFS_SENSE) rd_val[7:0] = sense_q;
    else if (wa == OFS_BOTH)  rd_val[7:0] = both_q;
    else if (wa == OFS_EVENT) rd_val[7:0] = event_q;
    else if (wa == OFS_IE)    rd_val[7:0] = ie_q;
    else if (wa == OFS_RAW)   rd_val[7:0] = raw_q;
    else if (wa == OFS_MIS)   rd_val[7:0] = raw_q & ie_q;
    else if (wa == OFS_MODE)  rd_val[7:0] = mode_q;
    else                      rd_bad = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rd_val : 32'h0;
      rsp_err   <= rd && rd_bad;
    end
  end

  assign pin_out   = data_q & dir_q;
  assign pin_oe    = dir_q;
  assign cfg_sense = sense_q;
  assign cfg_both  = both_q;
  assign cfg_event = event_q;
  assign cfg_ie    = ie_q;
  assign cfg_mode  = mode_q;
  assign irq_out   = |(raw_q & ie_q);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !$past(req_valid && req_write) |-> (((data_q ^ $past(data_q)) & dir_q) == 8'h00));

  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == 32'h0));

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    rsp_valid |-> $past(req_valid && !req_write));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    ((raw_q & $past(irq_set)) == $past(irq_set)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(req_valid && req_write && {req_addr[ADDR_W-1:2], 2'b00} == OFS_CLR)
      |-> ((raw_q & $past(req_wdata[7:0]) & ~$past(irq_set)) == 8'h00));

  assert_cfg_stable_R8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !$past(req_valid && req_write) |-> ($stable(dir_q) && $stable(ie_q) && $stable(mode_q)));
endmodule

// File: tb/gpio8_regs_bench.sv
module gpio8_regs_bench;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, rsp_err, irq_out;
  logic [31:0] rsp_rdata;
  logic [7:0] pin_in = 0, irq_set = 0;
  logic [7:0] pin_out, pin_oe, cfg_sense, cfg_both, cfg_event, cfg_ie, cfg_mode;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio8_regs u_gpio8_regs (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_rdata, .rsp_err, .pin_in, .pin_out, .pin_oe, .irq_set,
    .cfg_sense, .cfg_both, .cfg_event, .cfg_ie, .cfg_mode, .irq_out);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata; e = rsp_err;
    if (rsp_valid !== 1'b1) chk("R10 rsp_valid", {31'b0, rsp_valid}, 1);
  endtask

  task automatic test_reset();
    logic [31:0] d; logic e;
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 irq_out", irq_out, 0);
    rd(12'h3FC, d, e); chk("R1 data", d, 0);
    rd(12'h400, d, e); chk("R1 dir", d, 0);
    rd(12'h414, d, e); chk("R1 raw", d, 0);
  endtask

  task automatic test_config();
    logic [31:0] d; logic e;
    wr(12'h400, 32'hFFFF_FF0F); rd(12'h400, d, e); chk("R4 dir", d, 32'h0F);
    wr(12'h404, 32'hABCD_0011); rd(12'h404, d, e); chk("R4 sense", d, 32'h11);
    wr(12'h408, 32'h1234_5622); rd(12'h408, d, e); chk("R4 both", d, 32'h22);
    wr(12'h40C, 32'h8000_0033); rd(12'h40C, d, e); chk("R4 event", d, 32'h33);
    wr(12'h410, 32'hFFFF_FF0C); rd(12'h410, d, e); chk("R4 ie", d, 32'h0C);
    wr(12'h420, 32'h0000_0155); rd(12'h420, d, e); chk("R4 mode", d, 32'h55);
    chk("R4 ports", {cfg_sense, cfg_both, cfg_event, cfg_mode}, 32'h11223355);
    chk("R4 pin_oe", pin_oe, 8'h0F);
  endtask

  task automatic test_data();
    logic [31:0] d; logic e;
    wr(12'h014, 32'hFF);
    @(negedge clk); chk("R2 masked write", pin_out, 8'h05);
    wr(12'h3C0, 32'hFF);
    @(negedge clk); chk("R2 input bits not driven", pin_out, 8'h05);
    wr(12'h00C, 32'h00);
    @(negedge clk); chk("R2 clear bit0 keep bit2", pin_out, 8'h04);
    pin_in = 8'hA3;
    repeat (4) @(negedge clk);
    rd(12'h3FC, d, e); chk("R3 full mask read", d, 32'hA4);
    rd(12'h0C0, d, e); chk("R3 partial mask read", d, 32'h20);
    rd(12'h010, d, e); chk("R3 output bit read", d, 32'h04);
    pin_in = 8'h50;
    repeat (4) @(negedge clk);
    rd(12'h3FC, d, e); chk("R3 input follow", d, 32'h54);
  endtask

  task automatic test_irq();
    logic [31:0] d; logic e;
    @(negedge clk); irq_set = 8'h06;
    @(negedge clk); irq_set = 8'h00;
    rd(12'h414, d, e); chk("R5 raw", d, 32'h06);
    rd(12'h418, d, e); chk("R5 masked", d, 32'h04);
    chk("R5 irq_out high", irq_out, 1);
    wr(12'h41C, 32'h04);
    rd(12'h414, d, e); chk("R6 clear", d, 32'h02);
    chk("R5 irq_out low", irq_out, 0);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 12'h41C; req_wdata = 32'h02; irq_set = 8'h02;
    @(negedge clk);
    req_valid = 0; req_write = 0; irq_set = 0;
    rd(12'h414, d, e); chk("R6 set wins", d, 32'h02);
    wr(12'h41C, 32'hFF);
    rd(12'h414, d, e); chk("R6 clear all", d, 32'h00);
  endtask

  task automatic test_id();
    logic [31:0] d; logic e;
    logic [7:0] exp_b [8] = '{8'h61, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(i * 4), d, e);
      chk("R7 id byte", d, {24'h0, exp_b[i]});
    end
  endtask

  task automatic test_undef();
    logic [31:0] d; logic e;
    wr(12'hFE0, 32'h0);
    wr(12'h500, 32'hFF);
    wr(12'h418, 32'hFF);
    wr(12'h414, 32'hFF);
    rd(12'hFE0, d, e); chk("R8 id unchanged", d, 32'h61);
    rd(12'h400, d, e); chk("R8 dir unchanged", d, 32'h0F);
    rd(12'h410, d, e); chk("R8 ie unchanged", d, 32'h0C);
    rd(12'h420, d, e); chk("R8 mode unchanged", d, 32'h55);
    rd(12'h414, d, e); chk("R8 raw unchanged", d, 32'h00);
    chk("R8 pin_out unchanged", pin_out, 8'h04);
    rd(12'h500, d, e); chk("R9 undef data", d, 0); chk("R9 err", e, 1);
    @(negedge clk); chk("R9 err one cycle", rsp_err, 0);
    chk("R10 single pulse", rsp_valid, 0);
    rd(12'h41C, d, e); chk("R9 clr read err", e, 1);
    rd(12'h400, d, e); chk("R9 no err defined", e, 0);
    wr(12'h400, 32'h0F);
    chk("R10 no rsp on write", rsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_config();
    test_data();
    test_irq();
    test_id();
    test_undef();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule